// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the write side of a simple memory-mapped bus in front of an on-chip flash controller. It watches every write aimed at the flash control window and recognises fixed command sequences, one to 131 writes long. When a sequence completes, it raises a one-cycle command strobe with a command kind and the address that belongs to it. Downstream logic uses these strobes to change mode, erase, program, suspend, resume, clear status, handle lock bits or take a clock notification.

Every write address is first checked against a window that two entry bits select. Writes outside the enabled window are dropped and set a sticky address-error flag. Writes whose data breaks the sequence set a sticky command-error flag and abandon the partial sequence. During a program sequence the 128 data words go into an internal buffer. The program strobe fires only after the final confirm write, and the buffer can then be read through an index port.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, no strobe is raised, both error flags are 0 and the decoder is idle and not suspended. Cycles with no write never raise a strobe.
- R2: Single-write commands are decoded from data bits 7:0. They raise `cmd_valid` for exactly one cycle, in the cycle after the write, with the write address on `cmd_addr`. The opcodes map to `cmd_kind` as follows: FFh gives 1 (normal mode), 70h gives 2 (status read mode), B0h gives 4 (suspend) and 50h gives 6 (clear status).
- R3: 71h gives kind 3 (lock read mode 1) at once. If the next accepted write is D0h, it gives kind 8 (lock read 2) with that write's address. Any other next write is decoded as a fresh command. 77h followed by D0h gives kind 9 (lock program) with the D0h write's address.
- R4: 20h followed by D0h gives kind 7 (erase), with `cmd_addr` equal to the address of the D0h write.
- R5: A program sequence is E8h, then a count write equal to 80h, then 128 data words, then D0h. It gives kind 10 with the page address of the first data word. No strobe is raised before the D0h write. Afterwards word i can be read on `rd_word` with `rd_idx` = i.
- R6: A first program data word whose address is not 256-byte aligned sets the command error, raises no strobe and returns the decoder to idle.
- R7: E9h, then 03h, then 0F0Fh three times (all 16 bits compared), then D0h gives kind 11 (clock notification). No strobe is raised before the D0h write.
- R8: Wrong data in any cycle after the first of a sequence sets the sticky `cmd_err`, raises no strobe and returns the decoder to idle. Commands still work while the flag is set. Only 50h clears `cmd_err` and `addr_err`.
- R9: With entry bit 0 set, addresses 00F0_0000h to 00FF_FFFFh are accepted. With entry bit 1 set, addresses 00E0_0000h to 00EF_FFFFh are accepted. Any other write, including every write while both bits are 0, is ignored: there is no strobe and the sequence state is unchanged. Such a write sets `addr_err`.
- R10: With parameter `WIDE_WIN` = 0, the entry bit 1 window is never accepted.
- R11: D0h while idle and not suspended raises no strobe. After a suspend, the first D0h gives kind 5 (resume) and clears the suspended state.
- R12: An unknown opcode while idle sets `cmd_err` and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 32 | Bus write address |
| wr_data | input | 16 | Bus write data |
| entry_en | input | 2 | Window enables: bit 0 = F window, bit 1 = E window |
| rd_idx | input | IDX_W (7) | Buffer read index |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 4 | Command kind code |
| cmd_addr | output | 32 | Address captured for the command |
| cmd_err | output | 1 | Sticky sequence error |
| addr_err | output | 1 | Sticky address error |
| rd_word | output | 16 | Buffered program word at rd_idx |

## Verification
The bench targets four kinds of mistake.

The first is the 71h overlap, where one opcode both completes a command and opens another. A wrong decoder would either miss the lock read 2 strobe or swallow the following command.

The second is a rejected-address write arriving in the middle of an erase. If the decoder aborted or advanced its state on that write, the erase address would come out wrong or the strobe would be missing.

The third is the 128-word burst. The bench sweeps the whole buffer, so an off-by-one in the word counter shows up as a missing or early program strobe, or as shifted read-back data.

The fourth covers a misaligned page start, the resume that only a prior suspend enables, and the E window under `WIDE_WIN` = 0. Each of these would surface as a spurious or missing strobe or flag.

// File: rtl/fcsd_pkg.sv
package fcsd_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        K_NONE     = 4'd0,
        K_NORMAL   = 4'd1,
        K_STATRD   = 4'd2,
        K_LOCKRD1  = 4'd3,
        K_SUSPEND  = 4'd4,
        K_RESUME   = 4'd5,
        K_CLRSTAT  = 4'd6,
        K_ERASE    = 4'd7,
        K_LOCKRD2  = 4'd8,
        K_LOCKPROG = 4'd9,
        K_PROGRAM  = 4'd10,
        K_CLKNOTE  = 4'd11
    } cmd_kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ERASE, S_LOCKRD, S_LOCKPG, S_PGCNT,
        S_PGDATA, S_PGCONF, S_CKID, S_CKPAT, S_CKCONF
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        cmd_kind_e         kind;
        logic [ADDR_W-1:0] addr;
    } cmd_out_t;

    localparam logic [7:0]  OP_NORMAL = 8'hFF;
    localparam logic [7:0]  OP_STATRD = 8'h70;
    localparam logic [7:0]  OP_LOCKRD = 8'h71;
    localparam logic [7:0]  OP_SUSP   = 8'hB0;
    localparam logic [7:0]  OP_CONF   = 8'hD0;
    localparam logic [7:0]  OP_CLR    = 8'h50;
    localparam logic [7:0]  OP_ERASE  = 8'h20;
    localparam logic [7:0]  OP_LOCKPG = 8'h77;
    localparam logic [7:0]  OP_PROG   = 8'hE8;
    localparam logic [7:0]  OP_CLK    = 8'hE9;
    localparam logic [7:0]  OP_CLKID  = 8'h03;
    localparam logic [15:0] CLK_PAT   = 16'h0F0F;
    localparam int          CLK_REPS  = 3;

    localparam logic [11:0] WIN_F_TAG = 12'h00F;
    localparam logic [11:0] WIN_E_TAG = 12'h00E;

    function automatic logic in_win(logic [ADDR_W-1:0] a, logic [11:0] tag);
        return a[ADDR_W-1:20] == tag;
    endfunction

endpackage

// File: rtl/fcsd_win_chk.sv
module fcsd_win_chk
    import fcsd_pkg::*;
#(
    parameter bit WIDE_WIN = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        entry_en,
    output logic              ok
);
    logic hit_f, hit_e;

    generate
        if (WIDE_WIN) begin : g_wide
            assign hit_e = entry_en[1] && in_win(addr, WIN_E_TAG);
        end else begin : g_narrow
            assign hit_e = 1'b0;
        end
    endgenerate

    assign hit_f = entry_en[0] && in_win(addr, WIN_F_TAG);
    assign ok    = hit_f | hit_e;

    always_comb begin
        if (ok) a_r9_ok_needs_entry: assert (entry_en != 2'b00);
        if (ok && !WIDE_WIN) a_r10_narrow_only_f: assert (entry_en[0]);
    end
endmodule

// File: rtl/fcsd_word_buf.sv
module fcsd_word_buf
    import fcsd_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/fcsd_seq_fsm.sv
module fcsd_seq_fsm
    import fcsd_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr_ok,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_out_t          cmd,
    output logic              cmd_err,
    output logic              addr_err,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx
);
    localparam logic [7:0]       CNT_CODE = 8'(WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_PAT = IDX_W'(CLK_REPS - 1);

    seq_state_e        st, st_n;
    cmd_out_t          out_n;
    logic              err_n, aerr_n, susp, susp_n, decode;
    logic [IDX_W-1:0]  cnt, cnt_n;
    logic [ADDR_W-1:0] page, page_n;
    logic [7:0]        op;

    assign op      = wr_data[7:0];
    assign buf_idx = cnt;

    always_comb begin
        st_n   = st;
        out_n  = '{valid: 1'b0, kind: K_NONE, addr: '0};
        err_n  = cmd_err;
        aerr_n = addr_err;
        susp_n = susp;
        cnt_n  = cnt;
        page_n = page;
        buf_we = 1'b0;
        decode = 1'b0;
        if (wr_en && !addr_ok) begin
            aerr_n = 1'b1;
        end else if (wr_en) begin
            out_n.addr = wr_addr;
            case (st)
                S_IDLE:   decode = 1'b1;
                S_LOCKRD: begin
                    st_n = S_IDLE;
                    if (op == OP_CONF) begin
                        out_n.valid = 1'b1; out_n.kind = K_LOCKRD2;
                    end else decode = 1'b1;
                end
                S_ERASE, S_LOCKPG, S_CKCONF: begin
                    st_n = S_IDLE;
                    if (op == OP_CONF) begin
                        out_n.valid = 1'b1;
                        out_n.kind  = (st == S_ERASE)  ? K_ERASE :
                                      (st == S_LOCKPG) ? K_LOCKPROG : K_CLKNOTE;
                    end else err_n = 1'b1;
                end
                S_PGCNT: begin
                    if (op == CNT_CODE) begin
                        st_n = S_PGDATA; cnt_n = '0;
                    end else begin
                        st_n = S_IDLE; err_n = 1'b1;
                    end
                end
                S_PGDATA: begin
                    if (cnt == '0 && wr_addr[7:0] != 8'h00) begin
                        st_n = S_IDLE; err_n = 1'b1;
                    end else begin
                        buf_we = 1'b1;
                        if (cnt == '0) page_n = wr_addr;
                        if (cnt == LAST_IDX) st_n = S_PGCONF;
                        else cnt_n = cnt + 1'b1;
                    end
                end
                S_PGCONF: begin
                    st_n = S_IDLE;
                    if (op == OP_CONF) begin
                        out_n.valid = 1'b1; out_n.kind = K_PROGRAM; out_n.addr = page;
                    end else err_n = 1'b1;
                end
                S_CKID: begin
                    if (op == OP_CLKID) begin
                        st_n = S_CKPAT; cnt_n = '0;
                    end else begin
                        st_n = S_IDLE; err_n = 1'b1;
                    end
                end
                S_CKPAT: begin
                    if (wr_data != CLK_PAT) begin
                        st_n = S_IDLE; err_n = 1'b1;
                    end else if (cnt == LAST_PAT) st_n = S_CKCONF;
                    else cnt_n = cnt + 1'b1;
                end
                default: st_n = S_IDLE;
            endcase
            if (decode) begin
                case (op)
                    OP_NORMAL: begin out_n.valid = 1'b1; out_n.kind = K_NORMAL; end
                    OP_STATRD: begin out_n.valid = 1'b1; out_n.kind = K_STATRD; end
                    OP_LOCKRD: begin
                        out_n.valid = 1'b1; out_n.kind = K_LOCKRD1; st_n = S_LOCKRD;
                    end
                    OP_SUSP: begin
                        out_n.valid = 1'b1; out_n.kind = K_SUSPEND; susp_n = 1'b1;
                    end
                    OP_CONF: begin
                        if (susp) begin
                            out_n.valid = 1'b1; out_n.kind = K_RESUME; susp_n = 1'b0;
                        end
                    end
                    OP_CLR: begin
                        out_n.valid = 1'b1; out_n.kind = K_CLRSTAT;
                        err_n = 1'b0; aerr_n = 1'b0;
                    end
                    OP_ERASE:  st_n = S_ERASE;
                    OP_LOCKPG: st_n = S_LOCKPG;
                    OP_PROG:   st_n = S_PGCNT;
                    OP_CLK:    st_n = S_CKID;
                    default:   err_n = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cmd      <= '{valid: 1'b0, kind: K_NONE, addr: '0};
            cmd_err  <= 1'b0;
            addr_err <= 1'b0;
            susp     <= 1'b0;
            cnt      <= '0;
            page     <= '0;
        end else begin
            st       <= st_n;
            cmd      <= out_n;
            cmd_err  <= err_n;
            addr_err <= aerr_n;
            susp     <= susp_n;
            cnt      <= cnt_n;
            page     <= page_n;
        end
    end

    a_r1_no_write_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !cmd.valid);
    a_r9_reject_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr_ok) |=> $stable(st));
    a_r9_reject_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr_ok) |=> !cmd.valid);
    a_r5_prog_after_confirm: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.kind == K_PROGRAM) |-> $past(st) == S_PGCONF);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (cmd_err && !(wr_en && addr_ok && op == OP_CLR &&
                      (st == S_IDLE || st == S_LOCKRD))) |=> cmd_err);
    a_r5_index_bound: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < WORDS);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcsd_pkg::*;
#(
    parameter int WORDS    = 128,
    parameter bit WIDE_WIN = 1'b1,
    parameter int IDX_W    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        entry_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              cmd_valid,
    output logic [3:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_err,
    output logic              addr_err,
    output logic [DATA_W-1:0] rd_word
);
    logic             addr_ok, buf_we;
    logic [IDX_W-1:0] buf_idx;
    cmd_out_t         cmd;

    fcsd_win_chk #(.WIDE_WIN(WIDE_WIN)) u_win (
        .addr(wr_addr), .entry_en(entry_en), .ok(addr_ok)
    );

    fcsd_seq_fsm #(.WORDS(WORDS), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr_ok(addr_ok),
        .wr_addr(wr_addr), .wr_data(wr_data), .cmd(cmd),
        .cmd_err(cmd_err), .addr_err(addr_err),
        .buf_we(buf_we), .buf_idx(buf_idx)
    );

    fcsd_word_buf #(.WORDS(WORDS), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .we(buf_we), .widx(buf_idx), .wdata(wr_data),
        .ridx(rd_idx), .rdata(rd_word)
    );

    assign cmd_valid = cmd.valid;
    assign cmd_kind  = cmd.kind;
    assign cmd_addr  = cmd.addr;
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  entry_en = 2'b01;
    logic [6:0]  rd_idx = '0;
    logic        cmd_valid, cmd_err, addr_err;
    logic [3:0]  cmd_kind;
    logic [31:0] cmd_addr;
    logic [15:0] rd_word;
    logic        n_valid, n_err, n_aerr;
    logic [3:0]  n_kind;
    logic [31:0] n_addr;
    logic [15:0] n_word;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .entry_en(entry_en), .rd_idx(rd_idx), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_err(cmd_err),
        .addr_err(addr_err), .rd_word(rd_word)
    );

    flash_cmd_decoder #(.WIDE_WIN(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .entry_en(entry_en), .rd_idx(rd_idx), .cmd_valid(n_valid),
        .cmd_kind(n_kind), .cmd_addr(n_addr), .cmd_err(n_err),
        .addr_err(n_aerr), .rd_word(n_word)
    );

    localparam logic [31:0] CA = 32'h00F0_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input logic [3:0] k, input logic [31:0] a);
        chk(req, {31'b0, cmd_valid}, 32'd1);
        chk(req, {28'b0, cmd_kind}, {28'b0, k});
        chk(req, cmd_addr, a);
    endtask

    task automatic expect_none(input string req);
        chk(req, {31'b0, cmd_valid}, 32'd0);
    endtask

    function automatic logic [15:0] pword(input int i);
        return 16'((i * 771 + 16'h1234) & 16'hFFFF);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'b0, cmd_valid}, 0);
        chk("R1 err", {30'b0, cmd_err, addr_err}, 0);

        // R11 resume needs a prior suspend
        wr(CA, 16'h00D0); expect_none("R11 D0 idle");
        wr(CA, 16'h00B0); expect_cmd("R2 suspend", 4'd4, CA);
        wr(CA + 4, 16'h00D0); expect_cmd("R11 resume", 4'd5, CA + 4);
        wr(CA, 16'h00D0); expect_none("R11 second D0");

        // R2 single-write commands, one-cycle strobe
        wr(CA + 8, 16'h00FF); expect_cmd("R2 normal", 4'd1, CA + 8);
        @(negedge clk); expect_none("R2 one cycle");
        wr(CA, 16'h0070); expect_cmd("R2 status", 4'd2, CA);
        wr(CA, 16'h0050); expect_cmd("R2 clear", 4'd6, CA);

        // R3 lock bit commands
        wr(CA, 16'h0071); expect_cmd("R3 lockrd1", 4'd3, CA);
        wr(32'h00F1_2340, 16'h00D0); expect_cmd("R3 lockrd2", 4'd8, 32'h00F1_2340);
        wr(CA, 16'h0071); expect_cmd("R3 lockrd1 again", 4'd3, CA);
        wr(CA, 16'h00FF); expect_cmd("R3 fallthrough", 4'd1, CA);
        wr(CA, 16'h0077); expect_none("R3 lockpg first");
        wr(32'h00F2_0000, 16'h00D0); expect_cmd("R3 lockpg", 4'd9, 32'h00F2_0000);

        // R4 erase
        wr(CA, 16'h0020); expect_none("R4 erase first");
        wr(32'h00F3_1000, 16'h00D0); expect_cmd("R4 erase", 4'd7, 32'h00F3_1000);

        // R7 clock notification
        wr(CA, 16'h00E9); wr(CA, 16'h0003);
        for (int i = 0; i < 3; i++) begin
            wr(CA, 16'h0F0F); expect_none("R7 pattern");
        end
        wr(CA, 16'h00D0); expect_cmd("R7 clknote", 4'd11, CA);

        // R5 program burst and buffer sweep
        wr(CA, 16'h00E8); wr(CA, 16'h0080);
        for (int i = 0; i < 128; i++) begin
            wr(32'h00F4_0100 + 32'(2 * i), pword(i));
            if (cmd_valid) chk("R5 early strobe", 1, 0);
        end
        chk("R5 no err", {31'b0, cmd_err}, 0);
        wr(CA, 16'h00D0); expect_cmd("R5 program", 4'd10, 32'h00F4_0100);
        for (int i = 0; i < 128; i++) begin
            @(negedge clk); rd_idx = 7'(i); #1;
            chk("R5 readback", {16'b0, rd_word}, {16'b0, pword(i)});
        end

        // R6 misaligned page start
        wr(CA, 16'h00E8); wr(CA, 16'h0080);
        wr(32'h00F4_0102, 16'h1111); expect_none("R6 no strobe");
        chk("R6 err", {31'b0, cmd_err}, 1);
        wr(CA, 16'h00D0); expect_none("R6 back idle");
        // R8 sticky while commands still work; 50h clears
        wr(CA, 16'h00FF); expect_cmd("R8 works while err", 4'd1, CA);
        chk("R8 sticky", {31'b0, cmd_err}, 1);
        wr(CA, 16'h0050); chk("R8 cleared", {31'b0, cmd_err}, 0);

        // R8 wrong data mid-sequence
        wr(CA, 16'h0020); wr(CA, 16'h0070); expect_none("R8 erase broken");
        chk("R8 err erase", {31'b0, cmd_err}, 1);
        wr(CA, 16'h0050);
        wr(CA, 16'h00E9); wr(CA, 16'h0003); wr(CA, 16'h0F0F); wr(CA, 16'h0F0E);
        chk("R8 err clk pattern", {31'b0, cmd_err}, 1);
        wr(CA, 16'h00D0); expect_none("R8 clk dropped");
        wr(CA, 16'h0050);

        // R12 unknown opcode
        wr(CA, 16'h0033); expect_none("R12 no strobe");
        chk("R12 err", {31'b0, cmd_err}, 1);
        wr(CA, 16'h0050);

        // R9 address window
        wr(32'h00E0_0000, 16'h00FF); expect_none("R9 E window off");
        chk("R9 aerr", {31'b0, addr_err}, 1);
        wr(CA, 16'h0050); chk("R9 aerr clear", {31'b0, addr_err}, 0);
        wr(32'h0100_0000, 16'h00FF); expect_none("R9 above F window");
        entry_en = 2'b00;
        wr(CA, 16'h00FF); expect_none("R9 no entry");
        entry_en = 2'b01;
        wr(CA, 16'h0050);
        wr(CA, 16'h0020);
        wr(32'h00E0_0000, 16'h00D0); expect_none("R9 mid-seq reject");
        wr(32'h00F5_0000, 16'h00D0); expect_cmd("R9 state kept", 4'd7, 32'h00F5_0000);
        chk("R9 aerr mid", {31'b0, addr_err}, 1);
        wr(CA, 16'h0050);

        // R10 E window only with WIDE_WIN
        entry_en = 2'b10;
        wr(32'h00E0_0010, 16'h00FF); expect_cmd("R9 E window on", 4'd1, 32'h00E0_0010);
        chk("R10 narrow no strobe", {31'b0, n_valid}, 0);
        chk("R10 narrow aerr", {31'b0, n_aerr}, 1);
        wr(CA, 16'h00FF); expect_none("R9 F window off");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule